// File: doc/BRIEF.md
# Microsequenced accumulator processor

This block is a small single-bus processor built around one accumulator register. A hardwired sequencer walks each instruction through short runs of timed steps. Every instruction first passes through a fetch run. An indirect run may follow when the instruction asks for it. The execute run comes next. After a complete instruction, the processor may enter an interrupt run that records the return address and redirects control to a handler. The internal registers are the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator. They reach memory through one synchronous single-port interface, where the address is always the memory address register and the write data is always the memory buffer register.

Instruction words are 16 bits wide. Bits 15:13 hold the operation code, bit 12 is the indirect flag and bits 11:0 are the address field. The supported operations are add-to-accumulator, increment-and-skip-if-zero, branch-and-save-address, jump and halt. Each step either reads a register or writes it, never both, so an operation that reads a value from memory and then transforms it takes one step for the read and another for the transform. The interrupt request is sampled only at the boundary between instructions. Entering the interrupt run clears an internal enable that only reset sets again.

Top module: `accum_cpu`

## Requirements
- R1: Reset is asynchronous and active low, and it is released two clocks after `rst_n` rises. While reset is held, and until the first step, `mem_addr` is 0, `mem_we` is 0, `halted` is 0 and `acc_out` is 0. The first instruction is fetched from address 0.
- R2: A fetch takes three clocks: load the address from the program counter, capture the read data while incrementing the program counter, then copy the buffer into the instruction register. `mem_rdata` is taken in the clock after the address is presented.
- R3: Operation code 0 (add) adds the addressed word to the accumulator modulo 2^16 in three execute clocks.
- R4: When bit 12 is set, three extra clocks replace the address field with bits 11:0 of the word at that address before the execute run, for every operation except halt.
- R5: Operation code 1 (increment-and-skip) reads the addressed word, adds one, writes it back, and skips the next instruction when the new value is zero. The execute run takes four clocks.
- R6: Operation code 2 (branch-and-save) stores the address of the following instruction at the target and continues at target+1. The execute run takes three clocks.
- R7: Operation code 3 (jump) loads the address field into the program counter in one execute clock.
- R8: Operation code 7 (halt) enters a halted state right after its fetch. `halted` then stays 1 until reset, no memory write occurs and `irq` has no effect.
- R9: `irq` is acted on only after a complete instruction. The interrupt run takes three clocks. It writes the program counter to address SAVE_ADDR and continues fetching at HANDLER_ADDR.
- R10: The interrupt enable is cleared when the interrupt run is entered, and only reset sets it again. While `irq` stays high, a second interrupt run never starts.
- R11: Operation codes 4, 5 and 6 take one execute clock and change neither memory nor the accumulator.
- R12: `mem_we` is never high in two consecutive clocks. A write stores `mem_wdata` at `mem_addr` on the clock edge that ends the step in which `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data for the word at `mem_addr` |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Write data (memory buffer register) |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High while stopped by a halt instruction |
| acc_out | output | 16 | Accumulator value |

## Verification
The bench builds the processor with the default 12-bit address and 16-bit data widths. It moves the interrupt save and handler addresses from their defaults to 0x020 and 0x021, so a wrong parameter hookup shows up as a misplaced return address or a fetch from the wrong place. The modelled memory decodes 256 words, enough for the programs, pointers and operands at 0x000 to 0x0FF. Cycle counts from reset release to halt are compared against the sum of the per-run clock counts, which pins down the length of every run. One case keeps `irq` high through a whole handler, which exercises both the boundary sampling and the one-shot enable.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  localparam int unsigned OP_W   = 3;
  localparam int unsigned STEP_W = 2;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_ISZ  = 3'd1;
  localparam logic [OP_W-1:0] OP_BSA  = 3'd2;
  localparam logic [OP_W-1:0] OP_JMP  = 3'd3;
  localparam logic [OP_W-1:0] OP_HALT = 3'd7;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_IND   = 3'd1,
    CYC_EXEC  = 3'd2,
    CYC_INTR  = 3'd3,
    CYC_HALT  = 3'd4
  } cyc_e;

  // One bit per micro-operation issued in the current step
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_inc;
    logic pc_inc;
    logic pc_skip_zero;
    logic pc_from_ir;
    logic pc_from_handler;
    logic ir_from_mbr;
    logic iraddr_from_mbr;
    logic r1_add;
    logic mem_write;
  } ctl_t;

endpackage

// File: rtl/accum_cpu_rst_sync.sv
module accum_cpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/accum_cpu_seq.sv
module accum_cpu_seq
  import accum_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            irq,
  input  logic [OP_W-1:0] ir_op,
  input  logic [OP_W-1:0] mbr_op,
  input  logic            mbr_ind,
  output ctl_t            ctl,
  output logic            halted
);

  cyc_e              cyc_q, cyc_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              ien_q, ien_n;
  cyc_e              bnd_cyc;

  // Where control goes after a complete instruction
  always_comb begin
    bnd_cyc = (irq && ien_q) ? CYC_INTR : CYC_FETCH;
  end

  always_comb begin
    ctl    = '0;
    cyc_n  = cyc_q;
    step_n = step_q + STEP_W'(1);
    ien_n  = ien_q;
    unique case (cyc_q)
      CYC_FETCH: begin
        unique case (step_q)
          2'd0: ctl.mar_from_pc = 1'b1;
          2'd1: begin
            ctl.mbr_from_mem = 1'b1;
            ctl.pc_inc       = 1'b1;
          end
          default: begin
            ctl.ir_from_mbr = 1'b1;
            step_n = '0;
            if (mbr_op == OP_HALT) cyc_n = CYC_HALT;
            else if (mbr_ind)      cyc_n = CYC_IND;
            else                   cyc_n = CYC_EXEC;
          end
        endcase
      end
      CYC_IND: begin
        unique case (step_q)
          2'd0: ctl.mar_from_ir  = 1'b1;
          2'd1: ctl.mbr_from_mem = 1'b1;
          default: begin
            ctl.iraddr_from_mbr = 1'b1;
            step_n = '0;
            cyc_n  = CYC_EXEC;
          end
        endcase
      end
      CYC_EXEC: begin
        if (ir_op == OP_ADD) begin
          unique case (step_q)
            2'd0: ctl.mar_from_ir  = 1'b1;
            2'd1: ctl.mbr_from_mem = 1'b1;
            default: begin
              ctl.r1_add = 1'b1;
              step_n = '0;
              cyc_n  = bnd_cyc;
            end
          endcase
        end else if (ir_op == OP_ISZ) begin
          unique case (step_q)
            2'd0: ctl.mar_from_ir  = 1'b1;
            2'd1: ctl.mbr_from_mem = 1'b1;
            2'd2: ctl.mbr_inc      = 1'b1;
            default: begin
              ctl.mem_write    = 1'b1;
              ctl.pc_skip_zero = 1'b1;
              step_n = '0;
              cyc_n  = bnd_cyc;
            end
          endcase
        end else if (ir_op == OP_BSA) begin
          unique case (step_q)
            2'd0: begin
              ctl.mar_from_ir = 1'b1;
              ctl.mbr_from_pc = 1'b1;
            end
            2'd1: begin
              ctl.pc_from_ir = 1'b1;
              ctl.mem_write  = 1'b1;
            end
            default: begin
              ctl.pc_inc = 1'b1;
              step_n = '0;
              cyc_n  = bnd_cyc;
            end
          endcase
        end else begin
          ctl.pc_from_ir = (ir_op == OP_JMP);
          step_n = '0;
          cyc_n  = bnd_cyc;
        end
      end
      CYC_INTR: begin
        unique case (step_q)
          2'd0: begin
            ctl.mbr_from_pc = 1'b1;
            ien_n = 1'b0;
          end
          2'd1: begin
            ctl.mar_from_save   = 1'b1;
            ctl.pc_from_handler = 1'b1;
          end
          default: begin
            ctl.mem_write = 1'b1;
            step_n = '0;
            cyc_n  = CYC_FETCH;
          end
        endcase
      end
      default: begin
        step_n = '0;
        cyc_n  = CYC_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_FETCH;
      step_q <= '0;
      ien_q  <= 1'b1;
    end else begin
      cyc_q  <= cyc_n;
      step_q <= step_n;
      ien_q  <= ien_n;
    end
  end

  assign halted = (cyc_q == CYC_HALT);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> halted);

  // R12
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl.mem_write |=> !ctl.mem_write);

  // R9
  intr_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cyc_q == CYC_INTR && step_q == 2'd0) |-> (ien_q && $past(irq)));

  // R10
  intr_once_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cyc_q == CYC_INTR && step_q == 2'd2) |=> !ien_q);

endmodule

// File: rtl/accum_cpu_dp.sv
module accum_cpu_dp
  import accum_cpu_pkg::*;
#(
  parameter int unsigned AW           = 12,
  parameter int unsigned DW           = 16,
  parameter int unsigned SAVE_ADDR    = 0,
  parameter int unsigned HANDLER_ADDR = 1
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  ctl_t            ctl,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mar,
  output logic [DW-1:0]   mbr,
  output logic [DW-1:0]   r1,
  output logic [OP_W-1:0] ir_op,
  output logic [OP_W-1:0] mbr_op,
  output logic            mbr_ind
);

  localparam int unsigned PAD_W = DW - AW;

  logic [AW-1:0] pc_q, pc_n, mar_n;
  logic [DW-1:0] mbr_n, ir_q, ir_n, r1_n;
  logic          pc_en, mar_en, mbr_en, ir_en, r1_en;
  logic          mbr_zero;

  assign mbr_zero = (mbr == '0);

  always_comb begin
    pc_en  = ctl.pc_inc | ctl.pc_from_ir | ctl.pc_from_handler
           | (ctl.pc_skip_zero & mbr_zero);
    pc_n   = ctl.pc_from_handler ? AW'(HANDLER_ADDR) :
             ctl.pc_from_ir      ? ir_q[AW-1:0]      : pc_q + AW'(1);

    mar_en = ctl.mar_from_pc | ctl.mar_from_ir | ctl.mar_from_save;
    mar_n  = ctl.mar_from_pc ? pc_q :
             ctl.mar_from_ir ? ir_q[AW-1:0] : AW'(SAVE_ADDR);

    mbr_en = ctl.mbr_from_mem | ctl.mbr_from_pc | ctl.mbr_inc;
    mbr_n  = ctl.mbr_from_mem ? mem_rdata :
             ctl.mbr_from_pc  ? {{PAD_W{1'b0}}, pc_q} : mbr + DW'(1);

    ir_en  = ctl.ir_from_mbr | ctl.iraddr_from_mbr;
    ir_n   = ctl.ir_from_mbr ? mbr : {ir_q[DW-1:AW], mbr[AW-1:0]};

    r1_en  = ctl.r1_add;
    r1_n   = r1 + mbr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      mar  <= '0;
      mbr  <= '0;
      ir_q <= '0;
      r1   <= '0;
    end else begin
      if (pc_en)  pc_q <= pc_n;
      if (mar_en) mar  <= mar_n;
      if (mbr_en) mbr  <= mbr_n;
      if (ir_en)  ir_q <= ir_n;
      if (r1_en)  r1   <= r1_n;
    end
  end

  assign ir_op   = ir_q[DW-1 -: OP_W];
  assign mbr_op  = mbr[DW-1 -: OP_W];
  assign mbr_ind = mbr[AW];

  // R2
  fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl.mbr_from_mem && ctl.pc_inc) |=>
      (pc_q == $past(pc_q) + AW'(1)) && (mbr == $past(mem_rdata)));

  // R2
  ir_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl.ir_from_mbr |=> (ir_q == $past(mbr)) && $stable(mbr));

  // R3
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl.r1_add |=> r1 == $past(r1) + $past(mbr));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int unsigned AW           = 12,
  parameter int unsigned DW           = 16,
  parameter int unsigned SAVE_ADDR    = 0,
  parameter int unsigned HANDLER_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted,
  output logic [DW-1:0] acc_out
);

  logic            rst_ni;
  ctl_t            ctl;
  logic [OP_W-1:0] ir_op, mbr_op;
  logic            mbr_ind;

  accum_cpu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  accum_cpu_seq u_seq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .irq     (irq),
    .ir_op   (ir_op),
    .mbr_op  (mbr_op),
    .mbr_ind (mbr_ind),
    .ctl     (ctl),
    .halted  (halted)
  );

  accum_cpu_dp #(
    .AW           (AW),
    .DW           (DW),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mar       (mem_addr),
    .mbr       (mem_wdata),
    .r1        (acc_out),
    .ir_op     (ir_op),
    .mbr_op    (mbr_op),
    .mbr_ind   (mbr_ind)
  );

  assign mem_we = ctl.mem_write;

endmodule

// File: tb/accum_cpu_tb_top.sv
`timescale 1ns/1ps
module accum_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [15:0] acc_out;

  logic [15:0] mem [256];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  accum_cpu #(
    .SAVE_ADDR    (32'h020),
    .HANDLER_ADDR (32'h021)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .acc_out   (acc_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  function automatic logic [15:0] ins(input logic [2:0] op, input logic ind,
                                      input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  // Release reset and count clock edges until halted is seen
  task automatic run(output int n);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted || n > 2000) break;
    end
    if (!halted) begin
      fails++;
      checks++;
      $display("FAIL run timeout actual=%0d expected=halt", n);
    end
  endtask

  task automatic t_reset();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd7, 1'b0, 12'h000);
    @(negedge clk);
    check("R1 addr in reset", mem_addr, 0);
    check("R1 we in reset", mem_we, 0);
    check("R1 halted in reset", halted, 0);
    check("R1 acc in reset", acc_out, 0);
    run(n);
    check("R1 R8 halt cycles", n, 5);
  endtask

  task automatic t_add();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd0, 1'b0, 12'h080);
    mem[1] = ins(3'd0, 1'b0, 12'h081);
    mem[2] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'hFFF9;
    mem[8'h81] = 16'h000C;
    run(n);
    check("R3 add wrap", acc_out, 16'h0005);
    check("R2 R3 add cycles", n, 17);
  endtask

  task automatic t_indirect();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd0, 1'b1, 12'h090);
    mem[1] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h90] = 16'hF085;
    mem[8'h85] = 16'h0009;
    mem[8'h90 - 8'h10] = 16'h0000;
    run(n);
    check("R4 indirect operand", acc_out, 16'h0009);
    check("R4 indirect cycles", n, 14);
  endtask

  task automatic t_isz();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd1, 1'b0, 12'h080);
    mem[1] = ins(3'd0, 1'b0, 12'h081);
    mem[2] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'hFFFF;
    mem[8'h81] = 16'h0003;
    run(n);
    check("R5 isz wrote zero", mem[8'h80], 16'h0000);
    check("R5 isz skipped add", acc_out, 16'h0000);
    check("R5 isz skip cycles", n, 12);
    clear_mem();
    mem[0] = ins(3'd1, 1'b0, 12'h080);
    mem[1] = ins(3'd0, 1'b0, 12'h081);
    mem[2] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h0005;
    mem[8'h81] = 16'h0003;
    run(n);
    check("R5 isz increment", mem[8'h80], 16'h0006);
    check("R5 isz no skip", acc_out, 16'h0003);
    check("R5 isz cycles", n, 18);
  endtask

  task automatic t_bsa();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd2, 1'b0, 12'h040);
    mem[1] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h40] = 16'hABCD;
    mem[8'h41] = ins(3'd0, 1'b0, 12'h080);
    mem[8'h42] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h0004;
    run(n);
    check("R6 bsa saved return", mem[8'h40], 16'h0001);
    check("R6 bsa resumed at target+1", acc_out, 16'h0004);
    check("R6 bsa cycles", n, 17);
  endtask

  task automatic t_jmp();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd3, 1'b0, 12'h050);
    mem[1] = ins(3'd0, 1'b0, 12'h080);
    mem[8'h50] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h0007;
    run(n);
    check("R7 jmp skipped add", acc_out, 16'h0000);
    check("R7 jmp cycles", n, 9);
    clear_mem();
    mem[0] = ins(3'd3, 1'b1, 12'h060);
    mem[8'h60] = 16'h0050;
    mem[8'h50] = ins(3'd7, 1'b0, 12'h000);
    run(n);
    check("R4 R7 jmp indirect cycles", n, 12);
  endtask

  task automatic t_unused_op();
    int n;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd5, 1'b0, 12'h080);
    mem[1] = ins(3'd0, 1'b0, 12'h081);
    mem[2] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h1234;
    mem[8'h81] = 16'h0002;
    run(n);
    check("R11 noop mem untouched", mem[8'h80], 16'h1234);
    check("R11 noop acc", acc_out, 16'h0002);
    check("R11 noop cycles", n, 15);
  endtask

  task automatic t_irq();
    int n;
    int we_runs;
    logic prev_we;
    irq = 1'b1;
    clear_mem();
    mem[0] = ins(3'd0, 1'b0, 12'h080);
    mem[1] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h21] = ins(3'd0, 1'b0, 12'h081);
    mem[8'h22] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h0010;
    mem[8'h81] = 16'h0020;
    run(n);
    check("R9 saved pc", mem[8'h20], 16'h0001);
    check("R9 R10 handler ran once", acc_out, 16'h0030);
    check("R9 R10 irq cycles", n, 20);
    // R8: irq held high while halted
    we_runs = 0;
    prev_we = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_we && prev_we) we_runs++;
      prev_we = mem_we;
    end
    check("R8 halted holds", halted, 1);
    check("R8 R12 no write while halted", prev_we, 0);
    check("R9 save untouched", mem[8'h20], 16'h0001);
    irq = 1'b0;
  endtask

  task automatic t_halt_irq();
    int n;
    irq = 1'b1;
    clear_mem();
    mem[0] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h20] = 16'hBEEF;
    run(n);
    repeat (6) @(negedge clk);
    check("R8 halt ignores irq", mem[8'h20], 16'hBEEF);
    check("R8 halted stays", halted, 1);
    irq = 1'b0;
  endtask

  // R12: write strobe spacing and data on a branch-and-save sequence
  task automatic t_write();
    int n;
    int wr_cnt;
    int pair;
    logic prev;
    irq = 1'b0;
    clear_mem();
    mem[0] = ins(3'd1, 1'b0, 12'h080);
    mem[1] = ins(3'd2, 1'b0, 12'h040);
    mem[8'h41] = ins(3'd7, 1'b0, 12'h000);
    mem[8'h80] = 16'h0007;
    @(negedge clk);
    rst_n = 1'b1;
    wr_cnt = 0;
    pair = 0;
    prev = 1'b0;
    n = 0;
    while (!halted && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (mem_we) wr_cnt++;
      if (mem_we && prev) pair++;
      prev = mem_we;
    end
    check("R12 write count", wr_cnt, 2);
    check("R12 no back-to-back write", pair, 0);
    check("R12 isz data", mem[8'h80], 16'h0008);
    check("R12 bsa data", mem[8'h40], 16'h0002);
  endtask

  initial begin
    #(400000ns);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_indirect();
    t_isz();
    t_bsa();
    t_jmp();
    t_unused_op();
    t_irq();
    t_halt_irq();
    t_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule